// File: doc/BRIEF.md
# External Pin Interrupt Conditioner

This block watches a small group of external interrupt pins and converts their activity into one request line per pin for a downstream interrupt controller. Each pin passes through a two-flop synchroniser. A 2-bit sense field per pin selects how the pin is watched: active-low level, rising edge, falling edge or either edge. In an edge mode a detected event is held in a status flag until software clears it by writing a one to that flag bit. In level mode the flag tracks the inverted pin and cannot be latched.

Software uses a small synchronous register bus to set the sense fields, the pin directions, the per-pin request enables and the output data, and to read back the synchronised pin levels. Pin position 0 is reserved. It never flags and never requests. A pin must be configured as an input before its flag can reach its request output.

Top module: `edge_irq_unit`

## Requirements
- R1: After reset every register reads 0, except the data register, which reads the synchronised pins (0xFF with all pins idle high). `irq_req`, `pin_oe` and `pin_out` are 0.
- R2: The sense field for pin n sits at bits [2n+1:2n] of the 16-bit sense register (address 0). Code 00 selects level, 01 rising, 10 falling and 11 both edges.
- R3: In level mode the flag bit (register at address 4) reads 1 while the synchronised pin is low and 0 while it is high. It is not latched.
- R4: In rising mode a low-to-high pin transition sets the flag. The flag stays set after the pin returns low.
- R5: In falling mode a high-to-low transition sets the flag. A low-to-high transition does not set it.
- R6: In both-edge mode either transition sets the flag.
- R7: In an edge mode, writing 1 to a flag bit clears that bit. Writing 0 leaves the bit unchanged.
- R8: When a qualifying edge and a clearing write to the same flag bit fall on the same clock, the flag ends up set.
- R9: A clearing write in level mode has no effect: the flag still reads 1 while the pin is held low.
- R10: `irq_req[n]` is the flag ANDed with enable bit n (address 3) and with an input direction. Direction bit n at address 1 is 0 for input and 1 for output. Bit 0 of both the flags and the requests is always 0.
- R11: `pin_oe` equals the direction register. `pin_out` equals the data register (address 2) ANDed with the direction register.
- R12: A read of address 2 returns the pin levels as seen after the synchroniser.
- R13: A pin change applied just after a clock edge reaches the flag register after three rising edges and `irq_req` after four. A register read returns its data one edge after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write (1) or read (0) when strobed |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data, valid one edge after a read |
| pin_in | input | 8 | External pin levels |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| irq_req | output | 8 | Per-pin interrupt requests |

## Verification
After a pin changes, the flag is due three edges later and the request four edges later. The reads and request checks wait that many ticks, and one check confirms the request is still low at the third tick. Read data is registered, so the scoreboard queues each expected word when the read is issued and compares it at the falling edge after the capturing edge. The set-versus-clear collision lines up the clearing write with the exact edge at which the flag sets: the third edge after the pin change.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int PIN_W  = 8;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_SENSE = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIR   = 3'd1;
  localparam logic [ADDR_W-1:0] A_DATA  = 3'd2;
  localparam logic [ADDR_W-1:0] A_EN    = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAG  = 3'd4;

  typedef enum logic [1:0] {
    SENSE_LEVEL = 2'b00,
    SENSE_RISE  = 2'b01,
    SENSE_FALL  = 2'b10,
    SENSE_BOTH  = 2'b11
  } sense_e;
endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '1;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/edge_irq_detect.sv
module edge_irq_detect
  import edge_irq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   lvl,
  input  logic [2*W-1:0] sense,
  input  logic [W-1:0]   clr,
  output logic [W-1:0]   flag
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '1;
    else     prev_q <= lvl;
  end

  for (genvar n = 0; n < W; n++) begin : g_pin
    sense_e md;
    logic   rise, fall, hit;
    assign md   = sense_e'(sense[2*n+1:2*n]);
    assign rise = lvl[n] & ~prev_q[n];
    assign fall = ~lvl[n] & prev_q[n];
    always_comb begin
      case (md)
        SENSE_RISE: hit = rise;
        SENSE_FALL: hit = fall;
        SENSE_BOTH: hit = rise | fall;
        default:    hit = 1'b0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst)                    flag[n] <= 1'b0;
      else if (md == SENSE_LEVEL) flag[n] <= ~lvl[n];
      else if (hit)               flag[n] <= 1'b1;
      else if (clr[n])            flag[n] <= 1'b0;
    end

    // R7
    clear_works_chk: assert property (@(posedge clk) disable iff (rst)
      (md != SENSE_LEVEL && clr[n] && !hit) |=> !flag[n]);
    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (md != SENSE_LEVEL && hit) |=> flag[n]);
  end
endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
  import edge_irq_pkg::*;
#(
  parameter int W  = 8,
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_en,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic [W-1:0]   lvl,
  input  logic [W-1:0]   flag_vis,
  output logic [2*W-1:0] sense_q,
  output logic [W-1:0]   dir_q,
  output logic [W-1:0]   en_q,
  output logic [W-1:0]   data_q,
  output logic [W-1:0]   clr
);
  localparam int PAD = DW - W;
  logic wr, rd;
  assign wr = bus_en & bus_we;
  assign rd = bus_en & ~bus_we;
  assign clr = (wr && bus_addr == A_FLAG) ? bus_wdata[W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q <= '0;
      dir_q   <= '0;
      en_q    <= '0;
      data_q  <= '0;
    end else if (wr) begin
      case (bus_addr)
        A_SENSE: sense_q <= bus_wdata[2*W-1:0];
        A_DIR:   dir_q   <= bus_wdata[W-1:0];
        A_DATA:  data_q  <= bus_wdata[W-1:0];
        A_EN:    en_q    <= bus_wdata[W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd) begin
      case (bus_addr)
        A_SENSE: bus_rdata <= sense_q;
        A_DIR:   bus_rdata <= {{PAD{1'b0}}, dir_q};
        A_DATA:  bus_rdata <= {{PAD{1'b0}}, lvl};
        A_EN:    bus_rdata <= {{PAD{1'b0}}, en_q};
        A_FLAG:  bus_rdata <= {{PAD{1'b0}}, flag_vis};
        default: bus_rdata <= '0;
      endcase
    end
  end

  // R1
  reset_clean_chk: assert property (@(posedge clk)
    rst |=> (dir_q == '0 && en_q == '0 && sense_q == '0 && data_q == '0));
endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit
  import edge_irq_pkg::*;
#(
  parameter int          W        = PIN_W,
  parameter int          DW       = DATA_W,
  parameter int          AW       = ADDR_W,
  parameter int          STAGES   = 2,
  parameter logic [7:0]  RESV_MSK = 8'h01
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic [W-1:0]  irq_req
);
  logic [W-1:0]   lvl, flag_raw, flag_vis, dir_q, en_q, data_q, clr;
  logic [2*W-1:0] sense_q;
  logic [W-1:0]   live_msk;

  assign live_msk = ~RESV_MSK[W-1:0];

  edge_irq_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(lvl));

  edge_irq_detect #(.W(W)) u_det (
    .clk(clk), .rst(rst), .lvl(lvl), .sense(sense_q), .clr(clr), .flag(flag_raw));

  assign flag_vis = flag_raw & live_msk;

  edge_irq_regs #(.W(W), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lvl(lvl), .flag_vis(flag_vis),
    .sense_q(sense_q), .dir_q(dir_q), .en_q(en_q), .data_q(data_q), .clr(clr));

  always_ff @(posedge clk) begin
    if (rst) irq_req <= '0;
    else     irq_req <= flag_vis & en_q & ~dir_q;
  end

  assign pin_oe  = dir_q;
  assign pin_out = data_q & dir_q;

  // R10
  req_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_req != '0) |-> ((irq_req & ~$past(en_q)) == '0));
  // R10
  req_needs_input_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_req != '0) |-> ((irq_req & $past(pin_oe)) == '0));
  // R10
  resv_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_req & RESV_MSK[W-1:0]) == '0);
  // R13
  req_follows_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_req != '0) |-> ((irq_req & ~$past(flag_vis)) == '0));
endmodule

// File: tb/edge_irq_unit_tb.sv
module edge_irq_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1;
  logic        bus_en = 0, bus_we = 0;
  logic [2:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic [7:0]  pin_in = 8'hFF;
  logic [7:0]  pin_out, pin_oe, irq_req;

  int total = 0, fails = 0;

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t sb[$];
  logic  rd_fire = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_irq_unit dut_i (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_req(irq_req));

  always @(posedge clk) rd_fire <= bus_en & ~bus_we;

  always @(negedge clk) begin
    if (rd_fire) begin
      item_t it;
      it = sb.pop_front();
      total++;
      if (bus_rdata !== it.exp) begin
        fails++;
        $display("FAIL %s rdata=%h expected=%h", it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(logic [2:0] a, logic [15:0] e, string tag);
    sb.push_back('{exp: e, tag: tag});
    bus_en = 1; bus_we = 0; bus_addr = a;
    tick();
    bus_en = 0;
  endtask

  task automatic chk8(logic [7:0] act, logic [7:0] e, string tag);
    total++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, e);
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk); cyc++;
    end
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    tick(3);
    rst = 0;
    tick();
    // R1 reset state
    chk8(irq_req, 8'h00, "R1 irq_req");
    chk8(pin_oe, 8'h00, "R1 pin_oe");
    chk8(pin_out, 8'h00, "R1 pin_out");
    rd(3'd0, 16'h0000, "R1 sense");
    rd(3'd1, 16'h0000, "R1 dir");
    rd(3'd3, 16'h0000, "R1 enable");
    rd(3'd4, 16'h0000, "R1 flag");
    rd(3'd2, 16'h00FF, "R1 data");

    // R3 level mode on pin 1
    wr(3'd3, 16'h0002);
    pin_in[1] = 0;
    tick(4);
    chk8(irq_req, 8'h02, "R3 level req");
    rd(3'd4, 16'h0002, "R3 level flag");
    rd(3'd2, 16'h00FD, "R12 sync data");
    // R9 ack in level mode harmless
    wr(3'd4, 16'h0002);
    rd(3'd4, 16'h0002, "R9 level ack");
    chk8(irq_req, 8'h02, "R9 req kept");
    pin_in[1] = 1;
    tick(4);
    chk8(irq_req, 8'h00, "R3 level release");
    rd(3'd4, 16'h0000, "R3 flag follows");

    // R2/R4 rising on pin 2 (bits 5:4 = 01)
    wr(3'd0, 16'h0010);
    rd(3'd0, 16'h0010, "R2 sense readback");
    wr(3'd3, 16'h0006);
    pin_in[2] = 0;
    tick(4);
    chk8(irq_req, 8'h00, "R4 fall ignored");
    pin_in[2] = 1;
    tick(4);
    chk8(irq_req, 8'h04, "R4 rise req");
    pin_in[2] = 0;
    tick(4);
    rd(3'd4, 16'h0004, "R4 latched");
    // R7 write-one-to-clear
    wr(3'd4, 16'h0000);
    rd(3'd4, 16'h0004, "R7 zero write");
    wr(3'd4, 16'h0004);
    rd(3'd4, 16'h0000, "R7 clear");
    chk8(irq_req, 8'h00, "R7 req drops");

    // R5 falling on pin 3 (bits 7:6 = 10)
    wr(3'd0, 16'h0090);
    wr(3'd3, 16'h000E);
    pin_in[3] = 0;
    tick(4);
    chk8(irq_req, 8'h08, "R5 fall req");
    wr(3'd4, 16'h0008);
    pin_in[3] = 1;
    tick(4);
    rd(3'd4, 16'h0000, "R5 rise ignored");

    // R6 both on pin 4 (bits 9:8 = 11)
    wr(3'd0, 16'h0390);
    wr(3'd3, 16'h001E);
    pin_in[4] = 0;
    tick(4);
    rd(3'd4, 16'h0010, "R6 fall sets");
    wr(3'd4, 16'h0010);
    pin_in[4] = 1;
    tick(4);
    rd(3'd4, 16'h0010, "R6 rise sets");

    // R8 edge coincides with clearing write
    pin_in[4] = 0;
    tick(2);
    wr(3'd4, 16'h0010);
    rd(3'd4, 16'h0010, "R8 set wins");
    wr(3'd4, 16'h0010);
    rd(3'd4, 16'h0000, "R8 later clear");

    // R10 direction gating
    pin_in[4] = 1;
    tick(4);
    chk8(irq_req, 8'h10, "R10 req before dir");
    wr(3'd1, 16'h0010);
    tick();
    chk8(irq_req, 8'h00, "R10 output pin blocks req");
    chk8(pin_oe, 8'h10, "R11 pin_oe");
    rd(3'd4, 16'h0010, "R10 flag untouched");
    wr(3'd1, 16'h0000);
    // R10 reserved bit 0
    wr(3'd3, 16'h00FF);
    pin_in[0] = 0;
    tick(4);
    chk8(irq_req, 8'h10, "R10 bit0 no req");
    rd(3'd4, 16'h0010, "R10 bit0 no flag");

    // R13 latency on pin 5 (level)
    pin_in[5] = 0;
    tick(3);
    chk8(irq_req, 8'h10, "R13 not yet at 3");
    tick();
    chk8(irq_req, 8'h30, "R13 req at 4");
    pin_in[5] = 1;
    tick(4);

    // R11 outputs, R12 data readback
    wr(3'd2, 16'h00A0);
    wr(3'd1, 16'h00A0);
    chk8(pin_out, 8'hA0, "R11 pin_out");
    chk8(pin_oe, 8'hA0, "R11 pin_oe dir");
    rd(3'd2, 16'h00FA, "R12 data reads pins");
    wr(3'd1, 16'h0020);
    chk8(pin_out, 8'h20, "R11 masked by dir");

    tick(2);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule